// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services a translation-buffer miss by fetching a page table entry from a two-level table held in memory. A miss arrives as a 32-bit virtual address. The walker splits it into a directory index, a table index and a 12-bit byte offset for 4 KB pages. It first reads the directory entry, which holds a pointer to a second-level table. It then reads the page table entry from that table. It returns the entry so it can be installed in the translation buffer, and the faulting access can then be retried.

If an entry on the path is not valid, the walk stops at that point. The walker then reports a fault that names the level that failed, directory or table, and returns no entry. Memory is reached through a read port that allows one outstanding request at a time. The walker holds the directory base address in a register of its own. Only one walk runs at a time.

Entry layout, used at both levels: bit 0 is valid, bits 2:1 are access rights, and bits 31:12 are a physical page number. Bits 11:3 are ignored. The directory index is virtual address bits 31:22 and the table index is bits 21:12. Each entry address is a table base plus four times the index.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req_valid` is 0, `done_valid` is 0 and the directory base register holds 0.
- R2: A request accepted in idle (`req_valid` and `req_ready` both 1 at a clock edge) makes `mem_req_valid` 1 in the next cycle. The address is then base + 4 × vaddr[31:22].
- R3: After a directory response with bit 0 set, the next cycle issues a table read at {entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R4: Each memory request lasts exactly one cycle. No new request is issued until the response to the previous one has arrived.
- R5: After a table response with bit 0 set, `done_valid` is 1 in the next cycle with `done_status` = 2'b00 and `done_pte` equal to the response word.
- R6: After a directory response with bit 0 clear, `done_valid` is 1 in the next cycle with `done_status` = 2'b01 and `done_pte` = 0, and no table read is issued.
- R7: After a table response with bit 0 clear, `done_valid` is 1 in the next cycle with `done_status` = 2'b10 and `done_pte` = 0.
- R8: While a walk is in progress, `req_ready` is 0. `req_valid` and `req_vaddr` have no effect, and the latched address alone steers both reads.
- R9: A base write (`base_wr_en` = 1) in idle loads `base_wr_data` with bits 11:0 cleared. A base write while a walk is in progress is ignored.
- R10: `done_valid` lasts one cycle, and `req_ready` is 1 in the cycle that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address of the miss |
| base_wr_en | input | 1 | Load the directory base register |
| base_wr_data | input | 32 | New directory base (low 12 bits dropped) |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_data | input | 32 | Entry word read from memory |
| done_valid | output | 1 | Walk result present for one cycle |
| done_status | output | 2 | 00 success, 01 directory fault, 10 table fault |
| done_pte | output | 32 | Final entry on success, zero on fault |

## Verification
The bench goes after three kinds of corner case. The first is invalid entries at each level. A walker that confuses the levels would report the wrong fault code, would still issue a table read after a bad directory entry, or would leak a stale entry on a fault. The second is the extreme directory indices 0 and 1023 and a base with low bits set. These expose a wrong index slice, a missing ×4 scale or an unmasked base as wrong request addresses. The third is stimulus during a walk: new requests with other addresses and base writes. A walker that re-latched the address or accepted the write would send a later read, or the next walk's first read, to the wrong address.

// File: rtl/pw_pkg.sv
package pw_pkg;

    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 10;
    localparam int PPN_W   = VA_W - OFF_W;
    localparam int ENT_LG2 = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ_DIR,
        S_WAIT_DIR,
        S_READ_PTE,
        S_WAIT_PTE,
        S_DONE
    } walk_state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_DIR_FLT = 2'b01,
        ST_TBL_FLT = 2'b10
    } walk_status_e;

    typedef struct packed {
        logic [PPN_W-1:0]     ppn;
        logic [OFF_W-4:0]     spare;
        logic [1:0]           rights;
        logic                 valid;
    } pw_entry_t;

    function automatic logic [VA_W-1:0] entry_addr(
        input logic [VA_W-1:0]  base,
        input logic [IDX_W-1:0] idx
    );
        logic [VA_W-1:0] scaled;
        scaled = {{(VA_W-IDX_W-ENT_LG2){1'b0}}, idx, {ENT_LG2{1'b0}}};
        return base + scaled;
    endfunction

endpackage

// File: rtl/pw_base_reg.sv
module pw_base_reg
    import pw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            idle,
    input  logic            wr_en,
    input  logic [VA_W-1:0] wr_data,
    output logic [VA_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
        end else if (wr_en && idle) begin
            base <= {wr_data[VA_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen
    import pw_pkg::*;
(
    input  logic             rd_table,
    input  logic [VA_W-1:0]  dir_base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PPN_W-1:0] tbl_ppn,
    output logic [VA_W-1:0]  addr
);
    localparam int TIDX_LO = OFF_W;
    localparam int DIDX_LO = OFF_W + IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;

    always_comb begin
        dir_idx = vaddr[DIDX_LO +: IDX_W];
        tbl_idx = vaddr[TIDX_LO +: IDX_W];
        if (rd_table) begin
            addr = entry_addr({tbl_ppn, {OFF_W{1'b0}}}, tbl_idx);
        end else begin
            addr = entry_addr(dir_base, dir_idx);
        end
    end
endmodule

// File: rtl/pw_walk_fsm.sv
module pw_walk_fsm
    import pw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             mem_resp_valid,
    input  logic [VA_W-1:0]  mem_resp_data,
    output logic             idle,
    output logic             mem_req_valid,
    output logic             rd_table,
    output logic [VA_W-1:0]  vaddr_q,
    output logic [PPN_W-1:0] ppn_q,
    output logic             done_valid,
    output logic [1:0]       done_status,
    output logic [VA_W-1:0]  done_pte
);
    walk_state_e  state;
    walk_status_e status_q;
    logic [VA_W-1:0] pte_q;
    pw_entry_t resp_ent;

    always_comb resp_ent = pw_entry_t'(mem_resp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            vaddr_q  <= '0;
            ppn_q    <= '0;
            pte_q    <= '0;
            status_q <= ST_OK;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        state   <= S_READ_DIR;
                    end
                end
                S_READ_DIR: state <= S_WAIT_DIR;
                S_WAIT_DIR: begin
                    if (mem_resp_valid) begin
                        if (resp_ent.valid) begin
                            ppn_q <= resp_ent.ppn;
                            state <= S_READ_PTE;
                        end else begin
                            pte_q    <= '0;
                            status_q <= ST_DIR_FLT;
                            state    <= S_DONE;
                        end
                    end
                end
                S_READ_PTE: state <= S_WAIT_PTE;
                S_WAIT_PTE: begin
                    if (mem_resp_valid) begin
                        if (resp_ent.valid) begin
                            pte_q    <= mem_resp_data;
                            status_q <= ST_OK;
                        end else begin
                            pte_q    <= '0;
                            status_q <= ST_TBL_FLT;
                        end
                        state <= S_DONE;
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign idle          = (state == S_IDLE);
    assign mem_req_valid = (state == S_READ_DIR) || (state == S_READ_PTE);
    assign rd_table      = (state == S_READ_PTE);
    assign done_valid    = (state == S_DONE);
    assign done_status   = status_q;
    assign done_pte      = pte_q;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        base_wr_en,
    input  logic [31:0] base_wr_data,
    output logic        mem_req_valid,
    output logic [31:0] mem_req_addr,
    input  logic        mem_resp_valid,
    input  logic [31:0] mem_resp_data,
    output logic        done_valid,
    output logic [1:0]  done_status,
    output logic [31:0] done_pte
);
    logic             idle;
    logic             rd_table;
    logic [VA_W-1:0]  vaddr_q;
    logic [PPN_W-1:0] ppn_q;
    logic [VA_W-1:0]  dir_base;

    pw_walk_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_vaddr      (req_vaddr),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .idle           (idle),
        .mem_req_valid  (mem_req_valid),
        .rd_table       (rd_table),
        .vaddr_q        (vaddr_q),
        .ppn_q          (ppn_q),
        .done_valid     (done_valid),
        .done_status    (done_status),
        .done_pte       (done_pte)
    );

    pw_base_reg u_base (
        .clk     (clk),
        .rst     (rst),
        .idle    (idle),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .base    (dir_base)
    );

    pw_addr_gen u_addr (
        .rd_table (rd_table),
        .dir_base (dir_base),
        .vaddr    (vaddr_q),
        .tbl_ppn  (ppn_q),
        .addr     (mem_req_addr)
    );

    assign req_ready = idle;
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_resp_valid,
    input logic        done_valid,
    input logic [1:0]  done_status,
    input logic [31:0] done_pte
);
    p_req_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> mem_req_valid);

    p_single_cycle_req_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);

    p_no_resp_and_req_r4: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !done_valid);

    p_ok_entry_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_status == 2'b00) |-> done_pte[0]);

    p_fault_zero_pte_r6: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_status != 2'b00) |-> (done_pte == 32'h0));

    p_status_legal_r7: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (done_status != 2'b11));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (!done_valid && req_ready));

    logic unused_resp;
    assign unused_resp = mem_resp_valid;
endmodule

bind pt_walker pw_checker u_pw_checker (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .mem_req_valid  (mem_req_valid),
    .mem_resp_valid (mem_resp_valid),
    .done_valid     (done_valid),
    .done_status    (done_status),
    .done_pte       (done_pte)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        done_valid;
    logic [1:0]  done_status;
    logic [31:0] done_pte;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;
    logic [31:0] base_model = '0;

    always #4 clk = ~clk;

    pt_walker dut (.*);

    // Memory contents: a pure function of the address.
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [19:0] ppn;
        ppn = a[31:12] ^ {a[11:2], a[11:2]} ^ 20'h3C5A9;
        return {ppn, 9'd0, a[4:3], ~(a[2] & a[5])};
    endfunction

    function automatic logic [31:0] dir_addr(input logic [31:0] b, input logic [31:0] va);
        return b + {20'd0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] tbl_addr(input logic [31:0] de, input logic [31:0] va);
        return {de[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
    endfunction

    function automatic logic [1:0] exp_status(input logic [31:0] b, input logic [31:0] va);
        logic [31:0] de;
        de = mem_word(dir_addr(b, va));
        if (!de[0]) return 2'b01;
        if (!mem_word(tbl_addr(de, va))[0]) return 2'b10;
        return 2'b00;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] v);
        base_wr_en   = 1'b1;
        base_wr_data = v;
        @(negedge clk);
        base_wr_en = 1'b0;
        base_model = {v[31:12], 12'h000};
    endtask

    task automatic walk(input logic [31:0] va, input int lat1, input int lat2,
                        input bit poke, input logic [31:0] poke_val);
        logic [31:0] da, de, ta, te;
        da = dir_addr(base_model, va);
        de = mem_word(da);
        ta = tbl_addr(de, va);
        te = mem_word(ta);
        check(req_ready == 1'b1, "R10 ready before walk", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req_valid == 1'b1, "R2 dir request", {31'd0, mem_req_valid}, 32'd1);
        check(mem_req_addr == da, "R2 dir address", mem_req_addr, da);
        check(req_ready == 1'b0, "R8 busy not ready", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < lat1; i++) begin
            req_valid = 1'b1;
            req_vaddr = $urandom;
            if (poke) begin
                base_wr_en   = 1'b1;
                base_wr_data = poke_val;
            end
            @(negedge clk);
            check(mem_req_valid == 1'b0, "R4 no request while waiting", {31'd0, mem_req_valid}, 32'd0);
        end
        req_valid  = 1'b0;
        base_wr_en = 1'b0;
        mem_resp_valid = 1'b1;
        mem_resp_data  = de;
        @(negedge clk);
        mem_resp_valid = 1'b0;
        mem_resp_data  = $urandom;
        if (!de[0]) begin
            check(done_valid == 1'b1, "R6 done after dir fault", {31'd0, done_valid}, 32'd1);
            check(done_status == 2'b01, "R6 dir fault status", {30'd0, done_status}, 32'd1);
            check(done_pte == 32'h0, "R6 zero entry", done_pte, 32'h0);
            check(mem_req_valid == 1'b0, "R6 no table read", {31'd0, mem_req_valid}, 32'd0);
        end else begin
            check(mem_req_valid == 1'b1, "R3 table request", {31'd0, mem_req_valid}, 32'd1);
            check(mem_req_addr == ta, "R3 table address", mem_req_addr, ta);
            for (int i = 0; i < lat2; i++) begin
                req_valid = 1'b1;
                req_vaddr = $urandom;
                @(negedge clk);
                check(mem_req_valid == 1'b0, "R4 single request", {31'd0, mem_req_valid}, 32'd0);
                check(done_valid == 1'b0, "R8 no early done", {31'd0, done_valid}, 32'd0);
            end
            req_valid = 1'b0;
            mem_resp_valid = 1'b1;
            mem_resp_data  = te;
            @(negedge clk);
            mem_resp_valid = 1'b0;
            mem_resp_data  = $urandom;
            check(done_valid == 1'b1, "R5 done after table read", {31'd0, done_valid}, 32'd1);
            if (te[0]) begin
                check(done_status == 2'b00, "R5 ok status", {30'd0, done_status}, 32'd0);
                check(done_pte == te, "R5 entry value", done_pte, te);
            end else begin
                check(done_status == 2'b10, "R7 table fault status", {30'd0, done_status}, 32'd2);
                check(done_pte == 32'h0, "R7 zero entry", done_pte, 32'h0);
            end
        end
        @(negedge clk);
        check(done_valid == 1'b0, "R10 done one cycle", {31'd0, done_valid}, 32'd0);
        check(req_ready == 1'b1, "R10 ready after done", {31'd0, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] find_va(input logic [1:0] want, input logic [31:0] seed);
        for (int i = 0; i < 4096; i++) begin
            logic [31:0] va;
            va = seed + 32'(i) * 32'h0040_1000;
            if (exp_status(base_model, va) == want) return va;
        end
        return seed;
    endfunction

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", {31'd0, req_ready}, 32'd1);
        check(mem_req_valid == 1'b0, "R1 reset no request", {31'd0, mem_req_valid}, 32'd0);
        check(done_valid == 1'b0, "R1 reset no done", {31'd0, done_valid}, 32'd0);
        // R1: base is zero, seen through the first directory address
        walk(32'hFFC0_3ABC, 1, 1, 1'b0, '0);

        // R9: low bits of the base dropped
        set_base(32'h1234_5FFF);
        walk(32'h0000_0123, 2, 1, 1'b0, '0);   // directory index 0
        walk(32'hFFFF_F000, 1, 2, 1'b0, '0);   // directory index 1023

        // R6, R7, R5 directed
        walk(find_va(2'b01, 32'h0100_0000), 2, 1, 1'b0, '0);
        walk(find_va(2'b10, 32'h0200_0000), 1, 3, 1'b0, '0);
        walk(find_va(2'b00, 32'h0300_0000), 3, 2, 1'b0, '0);

        // R9: write during a walk is ignored; next walk still uses old base
        walk(32'h5555_5000, 3, 1, 1'b1, 32'hABCD_E000);
        walk(32'h8020_1000, 1, 1, 1'b0, '0);

        for (int n = 0; n < 80; n++) begin
            if (n % 16 == 0) begin
                @(negedge clk);
                set_base($urandom);
            end
            walk($urandom, 1 + ($urandom % 4), 1 + ($urandom % 4), 1'b0, '0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule